// File: doc/BRIEF.md
# Out-of-Order Instruction Window with In-Order Retirement

This block is a circular instruction window for a dynamically scheduled core. Decode places one renamed instruction per cycle at the tail. An instruction's destination is named by the slot it lands in, and the window returns that slot number as the instruction's tag. Source operands arrive either with their values or with the tag of the slot that will produce them. Waiting sources watch a single completion port and take the result whose tag matches theirs.

Each cycle the window sends at most one instruction to a functional unit. It picks the lowest-numbered slot that holds an unissued instruction with both operands present. Results come back on the completion port in any order. Slots leave strictly from the head, and only once they have completed. A retiring slot either writes the architectural register file or reports its recorded exception. An exception empties everything behind it. A separate flush input empties the whole window at once.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: `disp_ready` is 1, `disp_tag` is 0, and neither `iss_valid` nor `ret_valid` is asserted.
- R2: An accepted dispatch occupies the slot given by `disp_tag` in that cycle. `disp_tag` then advances by one, modulo DEPTH.
- R3: With DEPTH slots occupied, `disp_ready` is 0. A `disp_valid` in that state changes no slot and does not advance `disp_tag`.
- R4: An instruction is offered on `iss_*` only while its slot is occupied, has not yet been issued, and has both operands present. `iss_op`, `iss_a` and `iss_b` carry its opcode and operand values.
- R5: When several slots qualify, the lowest slot number is issued. A slot is issued at most once per occupancy.
- R6: A completion with tag T and data X makes every occupied source waiting on T present with value X from the next cycle on.
- R7: A completion in the same cycle as a dispatch whose source waits on the completing tag makes that source present in the new slot.
- R8: A source dispatched with its ready flag set keeps the supplied value unchanged until issue.
- R9: The head slot retires only after it has completed, in dispatch order, with `ret_valid` high for one cycle. `ret_wen` equals its destination-enable, and `ret_reg` and `ret_data` carry its register and result.
- R10: A head slot whose cause is nonzero (zero means no exception) retires with `ret_exc`=1, `ret_wen`=0 and its cause on `ret_cause`. All younger slots are discarded in the same edge, and completions addressed to them are ignored.
- R11: While `flush` is high, `disp_ready`, `iss_valid` and `ret_valid` are 0. After the edge the window is empty and the next tag equals the head slot.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard every slot |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of dispatched instruction |
| disp_a_rdy | input | 1 | First source value is present |
| disp_a_tag | input | log2(DEPTH) | Producer slot of first source |
| disp_a_val | input | DATA_W | First source value |
| disp_b_rdy | input | 1 | Second source value is present |
| disp_b_tag | input | log2(DEPTH) | Producer slot of second source |
| disp_b_val | input | DATA_W | Second source value |
| disp_dst_en | input | 1 | Instruction writes a register |
| disp_dst_reg | input | AREG_W | Architectural destination register |
| disp_ready | output | 1 | Dispatch will be accepted |
| disp_tag | output | log2(DEPTH) | Slot given to the dispatch |
| iss_valid | output | 1 | Instruction sent to a functional unit |
| iss_tag | output | log2(DEPTH) | Slot of issued instruction |
| iss_op | output | OP_W | Opcode of issued instruction |
| iss_a | output | DATA_W | First operand value |
| iss_b | output | DATA_W | Second operand value |
| cpl_valid | input | 1 | Result returning |
| cpl_tag | input | log2(DEPTH) | Slot the result belongs to |
| cpl_data | input | DATA_W | Result value |
| cpl_cause | input | 4 | Exception cause, zero for none |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_wen | output | 1 | Register file write enable |
| ret_reg | output | AREG_W | Register file write address |
| ret_data | output | DATA_W | Register file write data |
| ret_exc | output | 1 | Retiring slot carries an exception |
| ret_cause | output | 4 | Cause of the retiring slot |

## Verification
A missed wake-up leaves an instruction stuck. Its issue never appears, retirement stalls at that slot, and the reference model flags the absent `iss_valid` within one cycle of the completion. A pointer off by one appears at once as a wrong `disp_tag`, or as a retirement from the wrong slot with the wrong register and data. A lost flush or exception clear appears on the next cycle as an issue or retirement of a discarded instruction.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int unsigned CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE = '0;
endpackage

// File: rtl/rob_wake.sv
module rob_wake #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              rdy_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              rdy_o,
    output logic [DATA_W-1:0] val_o
);
    logic hit;
    always_comb begin
        hit   = !rdy_i && cpl_valid && (cpl_tag == tag_i);
        rdy_o = rdy_i || hit;
        val_o = hit ? cpl_data : val_i;
    end
endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]                       req,
    output logic                               any,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rob_window.sv
module rob_window
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int AREG_W = 5,
    parameter int OP_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     disp_valid,
    input  logic [OP_W-1:0]          disp_op,
    input  logic                     disp_a_rdy,
    input  logic [$clog2(DEPTH)-1:0] disp_a_tag,
    input  logic [DATA_W-1:0]        disp_a_val,
    input  logic                     disp_b_rdy,
    input  logic [$clog2(DEPTH)-1:0] disp_b_tag,
    input  logic [DATA_W-1:0]        disp_b_val,
    input  logic                     disp_dst_en,
    input  logic [AREG_W-1:0]        disp_dst_reg,
    output logic                     disp_ready,
    output logic [$clog2(DEPTH)-1:0] disp_tag,
    output logic                     iss_valid,
    output logic [$clog2(DEPTH)-1:0] iss_tag,
    output logic [OP_W-1:0]          iss_op,
    output logic [DATA_W-1:0]        iss_a,
    output logic [DATA_W-1:0]        iss_b,
    input  logic                     cpl_valid,
    input  logic [$clog2(DEPTH)-1:0] cpl_tag,
    input  logic [DATA_W-1:0]        cpl_data,
    input  logic [CAUSE_W-1:0]       cpl_cause,
    output logic                     ret_valid,
    output logic                     ret_wen,
    output logic [AREG_W-1:0]        ret_reg,
    output logic [DATA_W-1:0]        ret_data,
    output logic                     ret_exc,
    output logic [CAUSE_W-1:0]       ret_cause
);
    localparam int TAG_W = $clog2(DEPTH);
    localparam int PTR_W = TAG_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    typedef struct packed {
        logic               live;
        logic               exec;
        logic               done;
        logic [OP_W-1:0]    op;
        logic               r1;
        logic [TAG_W-1:0]   t1;
        logic [DATA_W-1:0]  v1;
        logic               r2;
        logic [TAG_W-1:0]   t2;
        logic [DATA_W-1:0]  v2;
        logic               dvld;
        logic [AREG_W-1:0]  dreg;
        logic [DATA_W-1:0]  data;
        logic [CAUSE_W-1:0] cause;
    } ent_t;

    typedef struct packed {
        logic [PTR_W-1:0]       head;
        logic [PTR_W-1:0]       tail;
        ent_t [DEPTH-1:0]       ent;
    } st_t;

    st_t st_d, st_q;
    ent_t hd, sel, nw;
    logic [PTR_W-1:0] occ;
    logic full, empty;
    logic [DEPTH-1:0] req;
    logic pick_any;
    logic [TAG_W-1:0] pick_idx;

    // wake-up network: every stored source and both incoming sources
    logic [DEPTH-1:0]  w1r, w2r;
    logic [DATA_W-1:0] w1v [DEPTH];
    logic [DATA_W-1:0] w2v [DEPTH];
    logic              da_r, db_r;
    logic [DATA_W-1:0] da_v, db_v;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        rob_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_w1 (
            .rdy_i(st_q.ent[g].r1), .tag_i(st_q.ent[g].t1), .val_i(st_q.ent[g].v1),
            .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
            .rdy_o(w1r[g]), .val_o(w1v[g]));
        rob_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_w2 (
            .rdy_i(st_q.ent[g].r2), .tag_i(st_q.ent[g].t2), .val_i(st_q.ent[g].v2),
            .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
            .rdy_o(w2r[g]), .val_o(w2v[g]));
    end

    rob_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_wa (
        .rdy_i(disp_a_rdy), .tag_i(disp_a_tag), .val_i(disp_a_val),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .rdy_o(da_r), .val_o(da_v));
    rob_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_wb (
        .rdy_i(disp_b_rdy), .tag_i(disp_b_tag), .val_i(disp_b_val),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .rdy_o(db_r), .val_o(db_v));

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            req[i] = st_q.ent[i].live && !st_q.ent[i].exec
                     && st_q.ent[i].r1 && st_q.ent[i].r2;
        end
    end

    rob_pick #(.N(DEPTH)) u_pick (.req(req), .any(pick_any), .idx(pick_idx));

    always_comb begin
        st_d  = st_q;
        occ   = st_q.tail - st_q.head;
        full  = (occ == DEPTH_P);
        empty = (occ == '0);
        hd    = st_q.ent[st_q.head[TAG_W-1:0]];
        sel   = st_q.ent[pick_idx];

        disp_ready = !full && !flush;
        disp_tag   = st_q.tail[TAG_W-1:0];

        iss_valid = pick_any && !flush;
        iss_tag   = pick_idx;
        iss_op    = sel.op;
        iss_a     = sel.v1;
        iss_b     = sel.v2;

        ret_valid = !flush && !empty && hd.live && hd.done;
        ret_exc   = ret_valid && (hd.cause != CAUSE_NONE);
        ret_cause = hd.cause;
        ret_wen   = ret_valid && !ret_exc && hd.dvld;
        ret_reg   = hd.dreg;
        ret_data  = hd.data;

        // operand capture from the completion broadcast
        for (int i = 0; i < DEPTH; i++) begin
            st_d.ent[i].r1 = w1r[i];
            st_d.ent[i].v1 = w1v[i];
            st_d.ent[i].r2 = w2r[i];
            st_d.ent[i].v2 = w2v[i];
        end

        if (cpl_valid && st_q.ent[cpl_tag].live) begin
            st_d.ent[cpl_tag].done  = 1'b1;
            st_d.ent[cpl_tag].data  = cpl_data;
            st_d.ent[cpl_tag].cause = cpl_cause;
        end

        if (iss_valid) st_d.ent[pick_idx].exec = 1'b1;

        nw      = '0;
        nw.live = 1'b1;
        nw.op   = disp_op;
        nw.r1   = da_r;
        nw.t1   = disp_a_tag;
        nw.v1   = da_v;
        nw.r2   = db_r;
        nw.t2   = disp_b_tag;
        nw.v2   = db_v;
        nw.dvld = disp_dst_en;
        nw.dreg = disp_dst_reg;
        if (disp_valid && disp_ready) begin
            st_d.ent[st_q.tail[TAG_W-1:0]] = nw;
            st_d.tail = st_q.tail + PTR_ONE;
        end

        if (ret_valid) begin
            st_d.ent[st_q.head[TAG_W-1:0]].live = 1'b0;
            st_d.head = st_q.head + PTR_ONE;
            if (ret_exc) begin
                for (int i = 0; i < DEPTH; i++) st_d.ent[i].live = 1'b0;
                st_d.tail = st_q.head + PTR_ONE;
            end
        end

        if (flush) begin
            for (int i = 0; i < DEPTH; i++) st_d.ent[i].live = 1'b0;
            st_d.tail = st_q.head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: occupancy never exceeds the slot count
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);

    // R5: an issued slot is marked issued (or discarded) on the next cycle
    a_r5_issue_marks: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (st_q.ent[$past(iss_tag)].exec || !st_q.ent[$past(iss_tag)].live));

    // R9: each retirement moves the head by exactly one slot
    a_r9_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (st_q.head == $past(st_q.head) + PTR_ONE));

    // R10: an exceptional retirement leaves the window empty
    a_r10_exc_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_exc) |=> (st_q.head == st_q.tail));

    // R11: flush leaves the window empty
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.head == st_q.tail));
endmodule

// File: tb/rob_window_test.sv
module rob_window_test;
    localparam int D  = 8;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int OW = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, flush;
    logic disp_valid, disp_a_rdy, disp_b_rdy, disp_dst_en;
    logic [OW-1:0] disp_op;
    logic [2:0] disp_a_tag, disp_b_tag;
    logic [DW-1:0] disp_a_val, disp_b_val;
    logic [AW-1:0] disp_dst_reg;
    logic disp_ready;
    logic [2:0] disp_tag;
    logic iss_valid;
    logic [2:0] iss_tag;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_a, iss_b;
    logic cpl_valid;
    logic [2:0] cpl_tag;
    logic [DW-1:0] cpl_data;
    logic [CW-1:0] cpl_cause;
    logic ret_valid, ret_wen, ret_exc;
    logic [AW-1:0] ret_reg;
    logic [DW-1:0] ret_data;
    logic [CW-1:0] ret_cause;

    rob_window #(.DEPTH(D), .DATA_W(DW), .AREG_W(AW), .OP_W(OW)) uut (.*);

    int checks = 0, errors = 0, cyc = 0;
    bit fu_en = 0;
    int exc_rate = 0;

    // reference model state
    bit m_live[D], m_exec[D], m_done[D], m_r1[D], m_r2[D], m_dv[D];
    int m_t1[D], m_t2[D], m_v1[D], m_v2[D], m_op[D], m_dr[D], m_data[D], m_cause[D];
    int m_head = 0, m_tail = 0;
    bit e_drdy, e_iv, e_rv, e_rexc, e_wen;
    int e_itag, h;
    int q_tag[$], q_due[$], q_dat[$];

    task automatic chk(string rq, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    task automatic clr();
        flush = 0; disp_valid = 0; disp_op = 0;
        disp_a_rdy = 1; disp_a_tag = 0; disp_a_val = 0;
        disp_b_rdy = 1; disp_b_tag = 0; disp_b_val = 0;
        disp_dst_en = 0; disp_dst_reg = 0;
        cpl_valid = 0; cpl_tag = 0; cpl_data = 0; cpl_cause = 0;
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) m_live[i] = 0;
        q_tag.delete(); q_due.delete(); q_dat.delete();
    endtask

    task automatic model_out();
        int cnt = m_tail - m_head;
        e_drdy = (cnt < D) && !flush;
        e_iv = 0; e_itag = 0;
        for (int i = 0; i < D; i++)
            if (!e_iv && m_live[i] && !m_exec[i] && m_r1[i] && m_r2[i]) begin
                e_iv = 1; e_itag = i;
            end
        if (flush) e_iv = 0;
        h = m_head % D;
        e_rv   = !flush && cnt > 0 && m_live[h] && m_done[h];
        e_rexc = e_rv && m_cause[h] != 0;
        e_wen  = e_rv && !e_rexc && m_dv[h];
    endtask

    task automatic compare();
        chk("R3", "disp_ready", disp_ready, e_drdy);
        chk("R2", "disp_tag", disp_tag, m_tail % D);
        chk("R4", "iss_valid", iss_valid, e_iv);
        if (e_iv) begin
            chk("R5", "iss_tag", iss_tag, e_itag);
            chk("R4", "iss_op", iss_op, m_op[e_itag]);
            chk("R6 R8", "iss_a", iss_a, m_v1[e_itag]);
            chk("R6 R8", "iss_b", iss_b, m_v2[e_itag]);
        end
        chk("R9", "ret_valid", ret_valid, e_rv);
        if (e_rv) begin
            chk("R10", "ret_exc", ret_exc, e_rexc);
            chk("R9", "ret_wen", ret_wen, e_wen);
        end
        if (e_wen) begin
            chk("R9", "ret_reg", ret_reg, m_dr[h]);
            chk("R9", "ret_data", ret_data, m_data[h]);
        end
        if (e_rexc) chk("R10", "ret_cause", ret_cause, m_cause[h]);
    endtask

    task automatic model_upd();
        int t;
        for (int i = 0; i < D; i++) begin
            if (m_live[i] && !m_r1[i] && cpl_valid && m_t1[i] == cpl_tag) begin
                m_r1[i] = 1; m_v1[i] = cpl_data;
            end
            if (m_live[i] && !m_r2[i] && cpl_valid && m_t2[i] == cpl_tag) begin
                m_r2[i] = 1; m_v2[i] = cpl_data;
            end
        end
        if (cpl_valid && m_live[cpl_tag]) begin
            m_done[cpl_tag] = 1; m_data[cpl_tag] = cpl_data; m_cause[cpl_tag] = cpl_cause;
        end
        if (e_iv) begin
            m_exec[e_itag] = 1;
            q_tag.push_back(e_itag);
            q_due.push_back(cyc + $urandom_range(1, 4));
            q_dat.push_back((m_v1[e_itag] + m_v2[e_itag] + m_op[e_itag]) & 16'hffff);
        end
        if (disp_valid && e_drdy) begin
            t = m_tail % D;
            m_live[t] = 1; m_exec[t] = 0; m_done[t] = 0; m_cause[t] = 0; m_data[t] = 0;
            m_op[t] = disp_op; m_dv[t] = disp_dst_en; m_dr[t] = disp_dst_reg;
            m_t1[t] = disp_a_tag; m_t2[t] = disp_b_tag;
            m_r1[t] = disp_a_rdy; m_v1[t] = disp_a_val;
            m_r2[t] = disp_b_rdy; m_v2[t] = disp_b_val;
            if (!disp_a_rdy && cpl_valid && cpl_tag == disp_a_tag) begin m_r1[t] = 1; m_v1[t] = cpl_data; end
            if (!disp_b_rdy && cpl_valid && cpl_tag == disp_b_tag) begin m_r2[t] = 1; m_v2[t] = cpl_data; end
            m_tail++;
        end
        if (e_rv) begin
            m_live[h] = 0; m_head++;
            if (e_rexc) begin model_clear(); m_tail = m_head; end
        end
        if (flush) begin model_clear(); m_tail = m_head; end
    endtask

    task automatic step();
        if (fu_en) begin
            cpl_valid = 0;
            for (int k = 0; k < q_tag.size(); k++) begin
                if (q_due[k] <= cyc) begin
                    cpl_valid = 1; cpl_tag = q_tag[k][2:0]; cpl_data = q_dat[k][15:0];
                    cpl_cause = ($urandom_range(1, 100) <= exc_rate) ? 4'($urandom_range(1, 15)) : 4'd0;
                    q_tag.delete(k); q_due.delete(k); q_dat.delete(k);
                    break;
                end
            end
        end
        #1;
        model_out();
        compare();
        @(posedge clk);
        model_upd();
        cyc++;
        @(negedge clk);
        if (fu_en) cpl_valid = 0;
    endtask

    task automatic mk_src(output logic r, output logic [2:0] t, output logic [DW-1:0] v);
        int lt = (m_tail + D - 1) % D;
        r = 1; t = 3'($urandom_range(0, D - 1)); v = DW'($urandom);
        if (m_tail != m_head && m_live[lt] && $urandom_range(0, 1) == 1) begin
            t = 3'(lt);
            if (!m_done[lt]) r = 0;
            else v = DW'(m_data[lt]);
        end
    endtask

    task automatic put(int op, int a, int b, int rg);
        disp_valid = 1; disp_op = OW'(op);
        disp_a_rdy = 1; disp_a_val = DW'(a);
        disp_b_rdy = 1; disp_b_val = DW'(b);
        disp_dst_en = 1; disp_dst_reg = AW'(rg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        clr();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < D; i++) begin m_live[i] = 0; m_exec[i] = 0; m_done[i] = 0; end
        #1;
        // R1: reset state
        chk("R1", "disp_ready", disp_ready, 1);
        chk("R1", "disp_tag", disp_tag, 0);
        chk("R1", "iss_valid", iss_valid, 0);
        chk("R1", "ret_valid", ret_valid, 0);
        @(negedge clk);

        // R3: fill with no completions, then try once more
        fu_en = 0;
        for (int i = 0; i < D; i++) begin
            put(i % 4, 10 + i, 20 + i, i + 1);
            step();
        end
        clr(); disp_valid = 1; #1;
        chk("R3", "disp_ready when full", disp_ready, 0);
        step(); clr(); #1;
        chk("R3", "disp_tag unchanged when full", disp_tag, 0);
        fu_en = 1;
        repeat (40) step();
        chk("R9", "window drained", disp_ready, 1);

        // R7: completion and dependent dispatch in the same cycle
        fu_en = 0;
        base = m_tail % D;
        put(1, 5, 6, 7); step();
        clr(); step();
        put(2, 0, 1, 8); disp_a_rdy = 0; disp_a_tag = 3'(base);
        cpl_valid = 1; cpl_tag = 3'(base); cpl_data = 16'd77; step();
        clr(); #1;
        chk("R7", "iss_valid", iss_valid, 1);
        chk("R7", "iss_tag", iss_tag, (base + 1) % D);
        chk("R7", "iss_a", iss_a, 77);
        step();
        flush = 1; step(); clr();
        #1; chk("R11", "iss_valid after flush", iss_valid, 0);
        chk("R11", "disp_tag after flush", disp_tag, m_head % D);

        // R10: exception at the head discards the younger slot
        base = m_tail % D;
        put(0, 1, 2, 3); step();
        put(0, 3, 4, 5); step();
        clr(); step();
        cpl_valid = 1; cpl_tag = 3'(base); cpl_data = 16'd9; cpl_cause = 4'd5; step();
        clr(); #1;
        chk("R10", "ret_exc", ret_exc, 1);
        chk("R10", "ret_wen", ret_wen, 0);
        chk("R10", "ret_cause", ret_cause, 5);
        step(); #1;
        chk("R10", "disp_tag after exception", disp_tag, (base + 1) % D);
        chk("R10", "ret_valid after exception", ret_valid, 0);
        cpl_valid = 1; cpl_tag = 3'((base + 1) % D); cpl_data = 16'd4; step();
        clr(); #1;
        chk("R10", "stale completion ignored", ret_valid, 0);
        step();

        // R11: flush with dispatch pending
        base = m_tail % D;
        for (int i = 0; i < 3; i++) begin put(3, i, i, i); step(); end
        put(1, 1, 1, 1); flush = 1; #1;
        chk("R11", "disp_ready during flush", disp_ready, 0);
        chk("R11", "iss_valid during flush", iss_valid, 0);
        chk("R11", "ret_valid during flush", ret_valid, 0);
        step(); clr(); #1;
        chk("R11", "disp_tag after flush", disp_tag, base);
        chk("R11", "iss_valid empty", iss_valid, 0);
        step();

        // random traffic: out-of-order completion, wrap, exceptions, flushes
        fu_en = 1; exc_rate = 3;
        for (int n = 0; n < 4000; n++) begin
            clr();
            if ($urandom_range(0, 9) < 7) begin
                disp_valid = 1;
                disp_op = OW'($urandom);
                mk_src(disp_a_rdy, disp_a_tag, disp_a_val);
                mk_src(disp_b_rdy, disp_b_tag, disp_b_val);
                disp_dst_en = 1'($urandom);
                disp_dst_reg = AW'($urandom);
            end
            flush = ($urandom_range(0, 99) == 0);
            step();
        end
        clr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule